// File: doc/BRIEF.md
# Congestion Duration Performance Counter

This block measures how long a transmit output queue remains congested. Each cycle it compares the current queue depth against a programmable depth threshold. While the depth is at or above the threshold, a prescaler counts clock cycles. Each time that prescaler completes a programmable period of N cycles, a 16-bit duration counter advances by one. The counter therefore reports congested time in units of N cycles.

Software reaches the counter through a simple read/write register port, and the counter sits in the low half of a 32-bit register. A read returns the current value and clears the counter. A write loads a test value. When N is zero, the counter does not count. Instead of wrapping, the counter stops at its largest value.

Top module: `cong_dur_mon`

## Requirements
- R1: Congestion holds in a cycle when `q_depth >= depth_thresh`. After every N consecutive congested clock edges with `period` = N (N from 1 to 255), the counter grows by exactly one, and the new value is visible on `rd_data` after the Nth edge.
- R2: When `period` is 0, the counter does not count, whatever the queue depth is.
- R3: The counter stops at 0xFFFF. Further increments leave it at 0xFFFF.
- R4: `rd_data` always shows the current counter value. A cycle with `rd_en` high sets the counter to 0 after that edge.
- R5: A cycle with `wr_en` high loads `wr_data[15:0]` into the counter after that edge. Bits 31:16 of `wr_data` have no effect.
- R6: A write in the same cycle as a read or an increment takes priority over both. A read-clear in the same cycle as an increment takes priority, and the increment is lost.
- R7: `rd_data[31:16]` always reads 0. After reset, `rd_data` is 0.
- R8: The prescaler restarts from zero whenever congestion drops, and whenever `period` differs from its value in the previous cycle. A partial period is never carried over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_depth | input | 10 | Current output queue depth |
| depth_thresh | input | 10 | Depth at or above which the queue counts as congested |
| period | input | 8 | Prescale period N; 0 disables counting |
| rd_en | input | 1 | Register read strobe; clears the counter |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; only bits 15:0 are used |
| rd_data | output | 32 | Counter value, zero-extended |

## Verification
Every counter update lands on the clock edge that samples its cause: an increment, a clear or a write. Each of these is visible on `rd_data` one cycle later, and `rd_data` is a direct view of the counter register. An increment appears after the Nth congested edge. The prescaler itself is not visible, so the bench tracks prescaler phase and the previous period in its reference state. The bench drives inputs on the falling edge and advances its reference model by one edge. It compares `rd_data` at the next falling edge, so every comparison falls exactly one register stage after the stimulus.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
   typedef enum logic [1:0] {
      CNT_HOLD  = 2'd0,
      CNT_INC   = 2'd1,
      CNT_CLEAR = 2'd2,
      CNT_LOAD  = 2'd3
   } cnt_op_e;
endpackage

// File: rtl/cdm_congest_cmp.sv
module cdm_congest_cmp #(
   parameter int DEPTH_W = 10
) (
   input  logic [DEPTH_W-1:0] depth,
   input  logic [DEPTH_W-1:0] thresh,
   output logic               congested
);
   assign congested = (depth >= thresh);
endmodule

// File: rtl/cdm_prescaler.sv
module cdm_prescaler #(
   parameter int PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                active,
   input  logic [PERIOD_W-1:0] period,
   output logic                tick
);
   logic [PERIOD_W-1:0] phase;
   logic [PERIOD_W-1:0] period_q;
   logic                run;
   logic                last;

   assign run  = active && (period != '0) && (period == period_q);
   assign last = (phase == period - PERIOD_W'(1));
   assign tick = run && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= '0;
         period_q <= '0;
      end else begin
         period_q <= period;
         if (!run || last) phase <= '0;
         else              phase <= phase + PERIOD_W'(1);
      end
   end
endmodule

// File: rtl/cdm_sat_counter.sv
module cdm_sat_counter
   import cdm_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] value
);
   localparam logic [CNT_W-1:0] MAXV = '1;
   cnt_op_e          op;
   logic [CNT_W-1:0] inc_val;

   always_comb begin
      if (load)      op = CNT_LOAD;
      else if (clr)  op = CNT_CLEAR;
      else if (inc)  op = CNT_INC;
      else           op = CNT_HOLD;
   end

   generate
      if (SATURATE) begin : g_sat
         assign inc_val = (value == MAXV) ? value : value + CNT_W'(1);
      end else begin : g_wrap
         assign inc_val = value + CNT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) value <= '0;
      else begin
         case (op)
            CNT_LOAD:  value <= load_val;
            CNT_CLEAR: value <= '0;
            CNT_INC:   value <= inc_val;
            default:   value <= value;
         endcase
      end
   end
endmodule

// File: rtl/cong_dur_mon.sv
module cong_dur_mon #(
   parameter int DEPTH_W  = 10,
   parameter int PERIOD_W = 8,
   parameter int CNT_W    = 16,
   parameter int REG_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DEPTH_W-1:0]  q_depth,
   input  logic [DEPTH_W-1:0]  depth_thresh,
   input  logic [PERIOD_W-1:0] period,
   input  logic                rd_en,
   input  logic                wr_en,
   input  logic [REG_W-1:0]    wr_data,
   output logic [REG_W-1:0]    rd_data
);
   localparam int PAD_W = REG_W - CNT_W;

   generate
      if (CNT_W > REG_W) begin : g_bad_width
         $error("cong_dur_mon: CNT_W must not exceed REG_W");
      end
      if (PERIOD_W < 1 || DEPTH_W < 1) begin : g_bad_param
         $error("cong_dur_mon: PERIOD_W and DEPTH_W must be positive");
      end
   endgenerate

   logic             congested;
   logic             tick;
   logic [CNT_W-1:0] count;

   cdm_congest_cmp #(.DEPTH_W(DEPTH_W)) u_cmp (
      .depth     (q_depth),
      .thresh    (depth_thresh),
      .congested (congested)
   );

   cdm_prescaler #(.PERIOD_W(PERIOD_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (congested),
      .period (period),
      .tick   (tick)
   );

   cdm_sat_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (tick),
      .clr      (rd_en),
      .load     (wr_en),
      .load_val (wr_data[CNT_W-1:0]),
      .value    (count)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = {{PAD_W{1'b0}}, count};
      end else begin : g_nopad
         assign rd_data = count;
      end
   endgenerate
endmodule

// File: rtl/cdm_checker.sv
module cdm_checker #(
   parameter int DEPTH_W  = 10,
   parameter int PERIOD_W = 8,
   parameter int CNT_W    = 16,
   parameter int REG_W    = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [DEPTH_W-1:0]  q_depth,
   input logic [DEPTH_W-1:0]  depth_thresh,
   input logic [PERIOD_W-1:0] period,
   input logic                rd_en,
   input logic                wr_en,
   input logic [REG_W-1:0]    wr_data,
   input logic [REG_W-1:0]    rd_data
);
   localparam logic [CNT_W-1:0] MAXV = '1;

   // R2
   period_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (period == '0 && !rd_en && !wr_en) |=> $stable(rd_data));

   // R1
   uncongested_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_depth < depth_thresh && !rd_en && !wr_en) |=> $stable(rd_data));

   // R3
   saturation_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[CNT_W-1:0] == MAXV && !rd_en && !wr_en) |=> rd_data[CNT_W-1:0] == MAXV);

   // R4
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en) |=> rd_data == '0);

   // R5
   write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[CNT_W-1:0] == $past(wr_data[CNT_W-1:0]));

   // R7
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[REG_W-1:CNT_W] == '0);

   // R1
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && !wr_en) |=> (rd_data == $past(rd_data) || rd_data == $past(rd_data) + 1));
endmodule

bind cong_dur_mon cdm_checker #(
   .DEPTH_W(DEPTH_W), .PERIOD_W(PERIOD_W), .CNT_W(CNT_W), .REG_W(REG_W)
) u_cdm_checker (
   .clk(clk), .rst_n(rst_n), .q_depth(q_depth), .depth_thresh(depth_thresh),
   .period(period), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
);

// File: tb/cong_dur_mon_bench.sv
module cong_dur_mon_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 10, PW = 8, CW = 16, RW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] q_depth = '0;
   logic [DW-1:0] depth_thresh = 10'd8;
   logic [PW-1:0] period = '0;
   logic          rd_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [RW-1:0] wr_data = '0;
   logic [RW-1:0] rd_data;

   int n_tests = 0;
   int n_fail  = 0;

   logic [CW-1:0] m_cnt = '0;
   logic [PW-1:0] m_phase = '0;
   logic [PW-1:0] m_per_q = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cong_dur_mon u_cong_dur_mon (
      .clk(clk), .rst_n(rst_n), .q_depth(q_depth), .depth_thresh(depth_thresh),
      .period(period), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
   );

   function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c, input logic wr,
         input logic [CW-1:0] wv, input logic rd, input logic inc);
      if (wr) return wv;
      if (rd) return '0;
      if (inc) return (c == 16'hFFFF) ? c : c + 16'd1;
      return c;
   endfunction

   task automatic check(input string req, input logic [RW-1:0] exp);
      n_tests++;
      if (rd_data !== exp) begin
         n_fail++;
         $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
      end
   endtask

   // one clock edge with the currently driven inputs; model advanced alongside
   task automatic step(input string req);
      logic cong, run, inc;
      cong = (q_depth >= depth_thresh);
      run  = cong && period != 0 && period == m_per_q;
      inc  = run && (m_phase == period - 8'd1);
      m_cnt   = next_count(m_cnt, wr_en, wr_data[CW-1:0], rd_en, inc);
      m_phase = (!run || inc) ? 8'd0 : m_phase + 8'd1;
      m_per_q = period;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      check(req, {16'h0, m_cnt});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R7 reset", 32'h0);

      // R1: N=3, six congested cycles give 2
      period = 8'd3; step("R8 period set");
      q_depth = 10'd8;
      for (int i = 0; i < 6; i++) step("R1 count N=3");
      check("R1 two periods", 32'd2);
      // R8: congestion drop loses partial period
      step("R1"); step("R1");
      q_depth = 10'd7; step("R8 drop");
      q_depth = 10'd20; step("R8"); step("R8");
      check("R8 partial not carried", 32'd2);
      step("R8 third");
      check("R8 after restart", 32'd3);
      // R2: period 0
      period = 8'd0;
      for (int i = 0; i < 10; i++) step("R2 disabled");
      check("R2 no count", 32'd3);
      // R4: read clears
      rd_en = 1'b1; step("R4 clear");
      check("R4 cleared", 32'd0);
      // R5: write with upper bits set
      wr_en = 1'b1; wr_data = 32'hABCD_FFFE; step("R5 write");
      check("R5 low half loaded", 32'h0000_FFFE);
      // R3: saturation at N=1
      period = 8'd1; step("R8 period change");
      step("R3 reach max");
      check("R3 at max", 32'h0000_FFFF);
      for (int i = 0; i < 4; i++) step("R3 hold");
      check("R3 stays max R7", 32'h0000_FFFF);
      // R6: read collides with increment
      rd_en = 1'b1; step("R6 clear beats inc");
      check("R6 clear wins", 32'h0);
      // R6: write collides with read and increment
      wr_en = 1'b1; rd_en = 1'b1; wr_data = 32'h0000_1234; step("R6 write wins");
      check("R6 written value", 32'h1234);

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         q_depth = DW'($urandom_range(0, 15));
         if ($urandom_range(0, 49) == 0) period = PW'($urandom_range(0, 5));
         rd_en = ($urandom_range(0, 19) == 0);
         wr_en = ($urandom_range(0, 39) == 0);
         wr_data = (($urandom_range(0, 1) == 1) ? 32'hFFFF_FFF0 : 32'h0) | 32'($urandom_range(0, 15));
         step("R1 R6 random");
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule